// File: doc/BRIEF.md
# Two-Dimensional Electromagnetic Field Tile Stepper

This block advances a 2x2 patch of a two-dimensional transverse-magnetic field grid by one complete time step in a single feed-forward pass. It takes the electric field component Ez and the magnetic components Hx and Hy of the patch. It also takes the neighbouring values that the stencil needs from just outside the patch. It first forms the half-step magnetic values, then feeds those fresh values straight into the electric update. No result ever travels back toward the input.

Each pass consumes twenty signed fixed-point values and four coefficient inputs. It performs forty-eight arithmetic operations and emits twelve results: four new Hx, four new Hy and four new Ez. The coefficients are held at fixed values for a whole run. The patch enters and leaves on a valid/ready stream. The pipeline takes one patch per cycle and stalls as a whole when the consumer holds off. Walking the grid, applying boundary conditions and storing the fields are left to the logic around it.

Cell index k within a patch is row-major: k = 2*r + c. Row r is the i direction and column c is the j direction. A data word at position k of a packed bus occupies bits [k*DATA_W +: DATA_W].

Top module: `fdtd_tile_step`

## Requirements
- R1: New Hx of cell (r,c) equals old Hx plus gain_hx times the difference (Ez at column c+1 minus Ez at (r,c)). For c=1, the neighbour is ez_east word r.
- R2: New Hy of cell (r,c) equals old Hy plus gain_hy times the difference (Ez at row r+1 minus Ez at (r,c)). For r=1, the neighbour is ez_south word c.
- R3: New Ez of cell (r,c) is formed in two steps. First, old Ez is added to gain_ez_hx times (new Hx of (r,c) minus the Hx to its west), and the sum is saturated. Then gain_ez_hy times (new Hy of (r,c) minus the Hy to its north) is added, and the result is saturated again. For c=0 the western value is hx_west word r; for r=0 the northern value is hy_north word c. All other neighbours are the newly computed values.
- R4: A product is the full signed product shifted arithmetically right by FRAC_W bits (rounding toward minus infinity) and then saturated.
- R5: Every difference, sum and product saturates to the range -2^(DATA_W-1) .. 2^(DATA_W-1)-1.
- R6: out_data holds twelve words. Words 0-3 are the new Hx, words 4-7 the new Hy and words 8-11 the new Ez, each group in cell order k.
- R7: A patch accepted on a clock edge with no stall appears on out_data with out_valid high after the third following edge. Back-to-back patches are accepted one per cycle while out_ready stays high.
- R8: While out_valid is high and out_ready is low, in_ready is low, and on the next edge out_valid stays high and out_data is unchanged.
- R9: While rst_n is low at a clock edge, out_valid and out_data are cleared and in_ready is high afterwards.
- R10: Cycles without in_valid produce no output: out_valid rises only for accepted patches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input patch present |
| in_ready | output | 1 | Pipeline can take a patch this cycle |
| ez_in | input | 4*DATA_W | Current Ez of the four cells, order k |
| ez_east | input | 2*DATA_W | Ez in column 2, word r |
| ez_south | input | 2*DATA_W | Ez in row 2, word c |
| hx_in | input | 4*DATA_W | Previous half-step Hx of the four cells |
| hy_in | input | 4*DATA_W | Previous half-step Hy of the four cells |
| hx_west | input | 2*DATA_W | Current half-step Hx west of column 0, word r |
| hy_north | input | 2*DATA_W | Current half-step Hy north of row 0, word c |
| gain_hx | input | DATA_W | Coefficient of the Hx update |
| gain_hy | input | DATA_W | Coefficient of the Hy update |
| gain_ez_hx | input | DATA_W | Coefficient of the Hx difference in the Ez update |
| gain_ez_hy | input | DATA_W | Coefficient of the Hy difference in the Ez update |
| out_valid | output | 1 | Result patch present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 12*DATA_W | New Hx, Hy and Ez words, packed per R6 |

## Verification
All twelve results of a patch become visible together, after the third clock edge that follows the accepting edge. Stall cycles do not count toward that delay. The bench drives inputs and samples outputs one nanosecond after the falling edge. At that point it records every accepted patch into an ordered queue of expected results, and it pops the queue only on a cycle where out_valid and out_ready are both high. Because of this, the comparison does not depend on the delay. One directed patch instead counts edges explicitly, to pin the delay down at exactly three further edges. The stall checks take a snapshot of out_data before the edge and compare it after the edge.

// File: rtl/fdtd_pkg.sv
// Package fdtd_pkg
// Shared saturating fixed-point helpers for the field stepper. All arithmetic
// is carried in 64-bit signed containers and clamped to a caller-given width.
// Assumes width <= 31 so that a full product never exceeds the container.
package fdtd_pkg;

    function automatic logic signed [63:0] fx_clamp(input logic signed [63:0] v,
                                                     input int unsigned w);
        logic signed [63:0] hi;
        logic signed [63:0] lo;
        hi = (64'sd1 <<< (w - 1)) - 64'sd1;
        lo = -(64'sd1 <<< (w - 1));
        if (v > hi) return hi;
        if (v < lo) return lo;
        return v;
    endfunction

    function automatic logic signed [63:0] fx_add(input logic signed [63:0] a,
                                                   input logic signed [63:0] b,
                                                   input int unsigned w);
        return fx_clamp(a + b, w);
    endfunction

    function automatic logic signed [63:0] fx_sub(input logic signed [63:0] a,
                                                   input logic signed [63:0] b,
                                                   input int unsigned w);
        return fx_clamp(a - b, w);
    endfunction

    function automatic logic signed [63:0] fx_mul(input logic signed [63:0] a,
                                                   input logic signed [63:0] b,
                                                   input int unsigned frac,
                                                   input int unsigned w);
        logic signed [63:0] p;
        p = (a * b) >>> frac;
        return fx_clamp(p, w);
    endfunction

endpackage

// File: rtl/fdtd_delay.sv
// Module fdtd_delay
// Enable-gated shift line of DEPTH registers. DEPTH = 0 gives a wire.
// Assumes synchronous active-low reset clears every stage to zero.
module fdtd_delay #(
    parameter int WIDTH = 1,
    parameter int DEPTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    generate
        if (DEPTH == 0) begin : g_wire
            assign q = d;
        end else begin : g_line
            logic [WIDTH-1:0] sr [DEPTH];

            // Shift one position per enabled cycle.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int i = 0; i < DEPTH; i++) sr[i] <= '0;
                end else if (en) begin
                    sr[0] <= d;
                    for (int i = 1; i < DEPTH; i++) sr[i] <= sr[i-1];
                end
            end

            assign q = sr[DEPTH-1];
        end
    endgenerate

endmodule

// File: rtl/fdtd_h_unit.sv
// Module fdtd_h_unit
// One magnetic-component update: h_new = h_old + coef * (ez_next - ez_here).
// Two register stages: the saturated difference, then the product-and-sum.
// Assumes coef is steady while data is in flight.
module fdtd_h_unit
    import fdtd_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int FRAC_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en,
    input  logic signed [DATA_W-1:0] ez_here,
    input  logic signed [DATA_W-1:0] ez_next,
    input  logic signed [DATA_W-1:0] h_old,
    input  logic signed [DATA_W-1:0] coef,
    output logic signed [DATA_W-1:0] h_new
);

    logic signed [DATA_W-1:0] diff_q;
    logic signed [DATA_W-1:0] hold_q;

    // Stage A: spatial difference of Ez and alignment of the old value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            diff_q <= '0;
            hold_q <= '0;
        end else if (en) begin
            diff_q <= DATA_W'(fx_sub(64'(ez_next), 64'(ez_here), DATA_W));
            hold_q <= h_old;
        end
    end

    // Stage B: scaled difference added onto the old value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_new <= '0;
        end else if (en) begin
            h_new <= DATA_W'(fx_add(64'(hold_q),
                                    fx_mul(64'(coef), 64'(diff_q), FRAC_W, DATA_W),
                                    DATA_W));
        end
    end

endmodule

// File: rtl/fdtd_e_unit.sv
// Module fdtd_e_unit
// One electric-component update from fresh half-step magnetic values:
// ez_new = sat(sat(ez_old + kx*(hx_here-hx_west)) + ky*(hy_here-hy_north)).
// Two register stages: differences, then both products and both sums.
// Assumes the coefficients are steady while data is in flight.
module fdtd_e_unit
    import fdtd_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int FRAC_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en,
    input  logic signed [DATA_W-1:0] hx_here,
    input  logic signed [DATA_W-1:0] hx_west,
    input  logic signed [DATA_W-1:0] hy_here,
    input  logic signed [DATA_W-1:0] hy_north,
    input  logic signed [DATA_W-1:0] ez_old,
    input  logic signed [DATA_W-1:0] gain_x,
    input  logic signed [DATA_W-1:0] gain_y,
    output logic signed [DATA_W-1:0] ez_new
);

    logic signed [DATA_W-1:0] dx_q;
    logic signed [DATA_W-1:0] dy_q;
    logic signed [DATA_W-1:0] ez_q;
    logic signed [63:0]       partial;

    // Stage A: curl differences of the magnetic field.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dx_q <= '0;
            dy_q <= '0;
            ez_q <= '0;
        end else if (en) begin
            dx_q <= DATA_W'(fx_sub(64'(hx_here), 64'(hx_west), DATA_W));
            dy_q <= DATA_W'(fx_sub(64'(hy_here), 64'(hy_north), DATA_W));
            ez_q <= ez_old;
        end
    end

    // First accumulation, saturated before the second term joins.
    always_comb begin
        partial = fx_add(64'(ez_q), fx_mul(64'(gain_x), 64'(dx_q), FRAC_W, DATA_W), DATA_W);
    end

    // Stage B: second scaled term added and result registered.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ez_new <= '0;
        end else if (en) begin
            ez_new <= DATA_W'(fx_add(partial,
                                     fx_mul(64'(gain_y), 64'(dy_q), FRAC_W, DATA_W),
                                     DATA_W));
        end
    end

endmodule

// File: rtl/fdtd_tile_step.sv
// Module fdtd_tile_step
// Advances a 2x2 patch of a TM-mode field grid by one full step: eight
// magnetic updates (two stages) feed four electric updates (two stages).
// Whole-pipeline stall on output back-pressure; one patch per cycle otherwise.
// Assumes the coefficient inputs are constant while patches are in flight.
module fdtd_tile_step #(
    parameter int DATA_W = 16,
    parameter int FRAC_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic [4*DATA_W-1:0]     ez_in,
    input  logic [2*DATA_W-1:0]     ez_east,
    input  logic [2*DATA_W-1:0]     ez_south,
    input  logic [4*DATA_W-1:0]     hx_in,
    input  logic [4*DATA_W-1:0]     hy_in,
    input  logic [2*DATA_W-1:0]     hx_west,
    input  logic [2*DATA_W-1:0]     hy_north,
    input  logic [DATA_W-1:0]       gain_hx,
    input  logic [DATA_W-1:0]       gain_hy,
    input  logic [DATA_W-1:0]       gain_ez_hx,
    input  logic [DATA_W-1:0]       gain_ez_hy,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic [12*DATA_W-1:0]    out_data
);

    localparam int SIDE  = 2;
    localparam int CELLS = SIDE * SIDE;
    localparam int H_LAT = 2;
    localparam int E_LAT = 2;
    localparam int LAT   = H_LAT + E_LAT;

    logic adv;

    logic signed [DATA_W-1:0] ez_t   [CELLS];
    logic signed [DATA_W-1:0] ez_d   [CELLS];
    logic signed [DATA_W-1:0] hx_new [CELLS];
    logic signed [DATA_W-1:0] hy_new [CELLS];
    logic signed [DATA_W-1:0] hx_out [CELLS];
    logic signed [DATA_W-1:0] hy_out [CELLS];
    logic signed [DATA_W-1:0] ez_out [CELLS];
    logic signed [DATA_W-1:0] hxw_d  [SIDE];
    logic signed [DATA_W-1:0] hyn_d  [SIDE];

    // Global advance: every stage moves unless a held result is refused.
    assign adv      = !out_valid || out_ready;
    assign in_ready = adv;

    fdtd_delay #(.WIDTH(1), .DEPTH(LAT)) u_valid (
        .clk(clk), .rst_n(rst_n), .en(adv), .d(in_valid), .q(out_valid)
    );

    genvar r, c, s;
    generate
        for (s = 0; s < SIDE; s++) begin : g_edge
            fdtd_delay #(.WIDTH(DATA_W), .DEPTH(H_LAT)) u_hxw (
                .clk(clk), .rst_n(rst_n), .en(adv),
                .d(hx_west[s*DATA_W +: DATA_W]), .q(hxw_d[s])
            );
            fdtd_delay #(.WIDTH(DATA_W), .DEPTH(H_LAT)) u_hyn (
                .clk(clk), .rst_n(rst_n), .en(adv),
                .d(hy_north[s*DATA_W +: DATA_W]), .q(hyn_d[s])
            );
        end

        for (r = 0; r < SIDE; r++) begin : g_row
            for (c = 0; c < SIDE; c++) begin : g_col
                localparam int K = r * SIDE + c;
                logic signed [DATA_W-1:0] ez_right;
                logic signed [DATA_W-1:0] ez_below;
                logic signed [DATA_W-1:0] hx_left;
                logic signed [DATA_W-1:0] hy_above;

                assign ez_t[K] = ez_in[K*DATA_W +: DATA_W];

                if (c == SIDE - 1) begin : g_east
                    assign ez_right = ez_east[r*DATA_W +: DATA_W];
                    assign hx_left  = hx_new[K-1];
                end else begin : g_inner_c
                    assign ez_right = ez_in[(K+1)*DATA_W +: DATA_W];
                    assign hx_left  = hxw_d[r];
                end

                if (r == SIDE - 1) begin : g_south
                    assign ez_below = ez_south[c*DATA_W +: DATA_W];
                    assign hy_above = hy_new[K-SIDE];
                end else begin : g_inner_r
                    assign ez_below = ez_in[(K+SIDE)*DATA_W +: DATA_W];
                    assign hy_above = hyn_d[c];
                end

                fdtd_h_unit #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) u_hx (
                    .clk(clk), .rst_n(rst_n), .en(adv),
                    .ez_here(ez_t[K]), .ez_next(ez_right),
                    .h_old(hx_in[K*DATA_W +: DATA_W]), .coef(gain_hx),
                    .h_new(hx_new[K])
                );

                fdtd_h_unit #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) u_hy (
                    .clk(clk), .rst_n(rst_n), .en(adv),
                    .ez_here(ez_t[K]), .ez_next(ez_below),
                    .h_old(hy_in[K*DATA_W +: DATA_W]), .coef(gain_hy),
                    .h_new(hy_new[K])
                );

                fdtd_delay #(.WIDTH(DATA_W), .DEPTH(H_LAT)) u_ez_align (
                    .clk(clk), .rst_n(rst_n), .en(adv), .d(ez_t[K]), .q(ez_d[K])
                );

                fdtd_e_unit #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) u_ez (
                    .clk(clk), .rst_n(rst_n), .en(adv),
                    .hx_here(hx_new[K]), .hx_west(hx_left),
                    .hy_here(hy_new[K]), .hy_north(hy_above),
                    .ez_old(ez_d[K]), .gain_x(gain_ez_hx), .gain_y(gain_ez_hy),
                    .ez_new(ez_out[K])
                );

                fdtd_delay #(.WIDTH(DATA_W), .DEPTH(E_LAT)) u_hx_align (
                    .clk(clk), .rst_n(rst_n), .en(adv), .d(hx_new[K]), .q(hx_out[K])
                );

                fdtd_delay #(.WIDTH(DATA_W), .DEPTH(E_LAT)) u_hy_align (
                    .clk(clk), .rst_n(rst_n), .en(adv), .d(hy_new[K]), .q(hy_out[K])
                );

                assign out_data[K*DATA_W +: DATA_W]             = hx_out[K];
                assign out_data[(CELLS+K)*DATA_W +: DATA_W]     = hy_out[K];
                assign out_data[(2*CELLS+K)*DATA_W +: DATA_W]   = ez_out[K];
            end
        end
    endgenerate

endmodule

// File: rtl/fdtd_tile_step_chk.sv
// Module fdtd_tile_step_chk
// Protocol checker for the field stepper, bound into every instance.
// Tracks patches in flight with a small counter and checks stall holding,
// pipeline occupancy, bubbles and reset clearing.
module fdtd_tile_step_chk #(
    parameter int DATA_W = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic                 in_ready,
    input logic                 out_valid,
    input logic                 out_ready,
    input logic [12*DATA_W-1:0] out_data
);

    localparam int DEPTH = 4;

    logic [3:0] inflight;

    // Count accepted patches that have not yet been consumed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inflight <= '0;
        end else begin
            inflight <= inflight + 4'((in_valid && in_ready) ? 1 : 0)
                                 - 4'((out_valid && out_ready) ? 1 : 0);
        end
    end

    // R8: refused result is held steady across the edge.
    p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R7: never more patches in flight than pipeline stages.
    p_occupancy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        inflight <= 4'(DEPTH));

    // R10: with nothing accepted and outstanding, no result appears.
    p_no_phantom_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (inflight == 4'd0) |-> !out_valid);

    // R9: a reset edge empties the output.
    p_reset_clears_r9: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_data == '0));

endmodule

bind fdtd_tile_step fdtd_tile_step_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
);

// File: tb/fdtd_tile_step_tb.sv
// Bench for fdtd_tile_step: table-driven streaming, then directed cases.
module fdtd_tile_step_tb;

    localparam int W    = 16;
    localparam int FR   = 8;
    localparam int OUTW = 12 * W;
    localparam int ROWS = 6;
    localparam int TPR  = 8;

    // Stimulus table: four coefficients, base value and step per row.
    localparam int T_GHX [ROWS] = '{128, -200, 256, 32767, 5, 0};
    localparam int T_GHY [ROWS] = '{64, 300, 256, -32768, 1000, 0};
    localparam int T_GEX [ROWS] = '{32, 77, 256, 32767, -1000, 0};
    localparam int T_GEY [ROWS] = '{16, -90, 256, 32767, 3, 0};
    localparam int T_BASE[ROWS] = '{100, -1500, 30000, -32000, 0, 1234};
    localparam int T_STEP[ROWS] = '{37, 411, 9000, 12000, 1, 999};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic out_ready = 1'b1;
    logic in_ready, out_valid;
    logic [4*W-1:0] ez_in, hx_in, hy_in;
    logic [2*W-1:0] ez_east, ez_south, hx_west, hy_north;
    logic [W-1:0] gain_hx, gain_hy, gain_ez_hx, gain_ez_hy;
    logic [OUTW-1:0] out_data;

    int stim [20];
    int checks = 0;
    int failures = 0;
    logic [OUTW-1:0] exp_q [$];

    always #4 clk = ~clk;

    fdtd_tile_step #(.DATA_W(W), .FRAC_W(FR)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .ez_in(ez_in), .ez_east(ez_east), .ez_south(ez_south),
        .hx_in(hx_in), .hy_in(hy_in), .hx_west(hx_west), .hy_north(hy_north),
        .gain_hx(gain_hx), .gain_hy(gain_hy), .gain_ez_hx(gain_ez_hx),
        .gain_ez_hy(gain_ez_hy), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data)
    );

    function automatic longint sat(longint v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    function automatic longint fmul(longint a, longint b);
        return sat((a * b) >>> FR);
    endfunction

    function automatic longint sx(logic [W-1:0] v);
        return longint'($signed(v));
    endfunction

    // Reference: stim 0-3 Ez cells, 4-5 east, 6-7 south, 8-11 Hx, 12-15 Hy,
    // 16-17 west Hx, 18-19 north Hy.
    function automatic logic [OUTW-1:0] model();
        longint hx [4];
        longint hy [4];
        longint ez, nb, wv, nv, t;
        logic [OUTW-1:0] res;
        res = '0;
        for (int k = 0; k < 4; k++) begin
            nb = (k % 2 == 1) ? stim[4 + k/2] : stim[k+1];
            hx[k] = sat(stim[8+k] + fmul(sx(gain_hx), sat(nb - stim[k])));
            nb = (k / 2 == 1) ? stim[6 + k%2] : stim[k+2];
            hy[k] = sat(stim[12+k] + fmul(sx(gain_hy), sat(nb - stim[k])));
        end
        for (int k = 0; k < 4; k++) begin
            wv = (k % 2 == 0) ? stim[16 + k/2] : hx[k-1];
            nv = (k / 2 == 0) ? stim[18 + k%2] : hy[k-2];
            t  = sat(stim[k] + fmul(sx(gain_ez_hx), sat(hx[k] - wv)));
            ez = sat(t + fmul(sx(gain_ez_hy), sat(hy[k] - nv)));
            res[k*W +: W]     = W'(hx[k]);
            res[(4+k)*W +: W] = W'(hy[k]);
            res[(8+k)*W +: W] = W'(ez);
        end
        return res;
    endfunction

    task automatic apply();
        for (int k = 0; k < 4; k++) begin
            ez_in[k*W +: W] = W'(stim[k]);
            hx_in[k*W +: W] = W'(stim[8+k]);
            hy_in[k*W +: W] = W'(stim[12+k]);
        end
        for (int s = 0; s < 2; s++) begin
            ez_east[s*W +: W]  = W'(stim[4+s]);
            ez_south[s*W +: W] = W'(stim[6+s]);
            hx_west[s*W +: W]  = W'(stim[16+s]);
            hy_north[s*W +: W] = W'(stim[18+s]);
        end
    endtask

    task automatic check(logic ok, string req, logic [OUTW-1:0] act, logic [OUTW-1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Compare one result patch group by group (R1 Hx, R2 Hy, R3 Ez; R6 order).
    task automatic check_patch(logic [OUTW-1:0] act, logic [OUTW-1:0] exp, string ctx);
        check(act[0 +: 4*W] == exp[0 +: 4*W], {"R1 R6 Hx words ", ctx},
              OUTW'(act[0 +: 4*W]), OUTW'(exp[0 +: 4*W]));
        check(act[4*W +: 4*W] == exp[4*W +: 4*W], {"R2 R6 Hy words ", ctx},
              OUTW'(act[4*W +: 4*W]), OUTW'(exp[4*W +: 4*W]));
        check(act[8*W +: 4*W] == exp[8*W +: 4*W], {"R3 R6 Ez words ", ctx},
              OUTW'(act[8*W +: 4*W]), OUTW'(exp[8*W +: 4*W]));
    endtask

    // One cycle: score handshakes 1 ns after the falling edge, then advance.
    task automatic step(string ctx);
        logic stalled;
        logic [OUTW-1:0] held;
        #1;
        if (out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R10 result without accepted patch", out_data, '0);
            end else begin
                check_patch(out_data, exp_q.pop_front(), ctx);
            end
        end
        if (in_valid && in_ready) exp_q.push_back(model());
        stalled = out_valid && !out_ready;
        held = out_data;
        if (stalled) check(!in_ready, "R8 in_ready low while refused", OUTW'(in_ready), '0);
        @(posedge clk);
        @(negedge clk);
        if (stalled) check(out_valid && out_data == held, "R8 held result", out_data, held);
    endtask

    task automatic fill(int row, int tile);
        for (int n = 0; n < 20; n++)
            stim[n] = int'(sat(longint'(T_BASE[row]) +
                               longint'(T_STEP[row]) * longint'(((n + 3*tile) % 7) - 3)));
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        logic [OUTW-1:0] hand;
        int lfsr;
        for (int n = 0; n < 20; n++) stim[n] = 0;
        apply();
        gain_hx = '0; gain_hy = '0; gain_ez_hx = '0; gain_ez_hy = '0;
        repeat (3) @(negedge clk);
        #1;
        // R9: reset state.
        check(!out_valid && in_ready && out_data == '0, "R9 reset state",
              {out_data[OUTW-1:2], out_valid, in_ready}, OUTW'(1));
        rst_n = 1'b1;
        @(negedge clk);

        // Hand-worked patch: unit gains, only Ez(0,0) = 1.0 (R1 R2 R3 R7).
        gain_hx = 16'h0100; gain_hy = 16'h0100; gain_ez_hx = 16'h0100; gain_ez_hy = 16'h0100;
        stim[0] = 256;
        apply();
        hand = '0;
        hand[0*W +: W] = 16'hFF00;
        hand[4*W +: W] = 16'hFF00;
        hand[8*W +: W] = 16'hFF00;
        hand[9*W +: W] = 16'h0100;
        hand[10*W +: W] = 16'h0100;
        in_valid = 1'b1;
        out_ready = 1'b0;
        #1;
        exp_q.push_back(model());
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        for (int e = 0; e < 2; e++) begin
            @(posedge clk);
            @(negedge clk);
            #1;
            check(!out_valid, "R7 no result before third edge", OUTW'(out_valid), '0);
        end
        @(posedge clk);
        @(negedge clk);
        #1;
        check(out_valid, "R7 result after third edge", OUTW'(out_valid), OUTW'(1));
        check_patch(out_data, hand, "hand patch");
        out_ready = 1'b1;
        step("hand drain");

        // Table walk: back-to-back patches per row, then drain (R4 R5 R7).
        for (int row = 0; row < ROWS; row++) begin
            gain_hx = W'(T_GHX[row]); gain_hy = W'(T_GHY[row]);
            gain_ez_hx = W'(T_GEX[row]); gain_ez_hy = W'(T_GEY[row]);
            for (int t = 0; t < TPR; t++) begin
                fill(row, t);
                apply();
                in_valid = 1'b1;
                #1;
                check(in_ready, "R7 accepts one patch per cycle", OUTW'(in_ready), OUTW'(1));
                step($sformatf("R4 R5 row %0d", row));
            end
            in_valid = 1'b0;
            repeat (5) step("drain");
        end
        check(exp_q.size() == 0, "R7 every patch delivered", OUTW'(exp_q.size()), '0);

        // Back-pressure with irregular valid and ready (R8 R10).
        gain_hx = 16'h0180; gain_hy = 16'hFF40; gain_ez_hx = 16'h0055; gain_ez_hy = 16'h00C0;
        lfsr = 32'h1d;
        for (int t = 0; t < 40; t++) begin
            lfsr = ((lfsr << 1) | (((lfsr >> 4) ^ (lfsr >> 2)) & 1)) & 32'h1f;
            fill(t % ROWS, t);
            apply();
            in_valid = lfsr[0];
            out_ready = lfsr[1] | lfsr[3];
            step("R8 stall stream");
        end
        in_valid = 1'b0;
        out_ready = 1'b1;
        repeat (6) step("stall drain");
        check(exp_q.size() == 0, "R8 no patch lost under stall", OUTW'(exp_q.size()), '0);

        // Idle cycles give no output (R10).
        for (int t = 0; t < 4; t++) begin
            #1;
            check(!out_valid, "R10 idle no output", OUTW'(out_valid), '0);
            step("idle");
        end

        // Reset while full (R9).
        in_valid = 1'b1;
        out_ready = 1'b0;
        repeat (4) step("fill for reset");
        exp_q.delete();
        in_valid = 1'b0;
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        #1;
        check(!out_valid && out_data == '0 && in_ready, "R9 reset clears full pipe",
              out_data, '0);
        rst_n = 1'b1;
        out_ready = 1'b1;
        @(negedge clk);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule